// File: doc/BRIEF.md
# Phase Order Detector with Contactor Interlock

This block decides the rotation order of a three-phase supply from two digitized half-wave signals. One is the reference phase. The other is a second phase of unknown identity. Each signal is high for the positive half-cycle of its phase and low for the negative half-cycle.

On every rising edge of the second phase, the block samples the reference level. A high sample means the second phase lags the reference by a third of a period, so the wiring is in correct order. A low sample means it lags by two thirds, so the order is reversed. From that one bit the block enables one of two contactors: the one that wires the load straight through, or the one that swaps two phases.

Both enables stay off until the reference phase has been present without a break for a settle time. This keeps chattering or sparking temporary connections from switching the load on and off repeatedly. If the reference phase stops toggling, both enables drop at once. The full settle time then starts again when the phase returns. Both inputs are asynchronous and pass through two-flop synchronizers. Edges are found by comparing each synchronized level with its value one clock earlier.

Top module: `phase_order_interlock`

## Requirements
- R1: After reset both contactor enables are low.
- R2: When the reference level sampled at a second-phase rising edge is 1 and the block is enabled, `drive_straight_o` is high and `drive_swapped_o` is low.
- R3: When the reference level sampled at a second-phase rising edge is 0 and the block is enabled, `drive_swapped_o` is high and `drive_straight_o` is low.
- R4: Neither enable rises until the reference phase has been continuously present for `SETTLE_CYCLES` clock cycles. The ready state is transferred to the outputs only at a second-phase rising edge.
- R5: The two enables are never high in the same cycle.
- R6: If no reference rising edge is seen for `LOSS_CYCLES` cycles, the phase counts as lost, and both enables are low on the next cycle. This holds even when the second phase has also stopped.
- R7: Each loss of the reference phase clears the settle count. After the phase returns, the enables stay low for another full `SETTLE_CYCLES`, including when the phase drops out repeatedly.
- R8: Apart from a loss-triggered drop, an enable changes only in the cycle after a synchronized second-phase rising edge. A rewiring of the second input therefore takes effect at its next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_half_i | input | 1 | Reference phase half-wave, asynchronous |
| probe_half_i | input | 1 | Second phase half-wave, asynchronous |
| drive_straight_o | output | 1 | Enable for the contactor that keeps the wiring in order |
| drive_swapped_o | output | 1 | Enable for the contactor that swaps two phases |

## Verification
The bench drives both phase orders at random mains periods and places the probe edges well clear of the reference transitions. A design that inverted the sampled bit would energize the wrong contactor.

Settle-time checks sample the outputs partway through the delay. A design that enabled early, or that kept the count it had built up across a dropout, would switch on too soon after a reconnect or during a burst of chatter.

Loss cases remove the reference alone and then both inputs together. A design that waited for a second-phase edge before dropping its outputs would then hold the load energized with no mains present.

A live rewiring case checks that the old enable persists until the new rising edge of the second phase and only then changes over. Throughout the run, any cycle with both enables high is counted as an error.

// File: rtl/phase_order_interlock.sv
module phase_order_interlock #(
  parameter int SETTLE_CYCLES = 50_000_000,
  parameter int LOSS_CYCLES   = 1_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_half_i,
  input  logic probe_half_i,
  output logic drive_straight_o,
  output logic drive_swapped_o
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int LW = $clog2(LOSS_CYCLES + 1);

  logic [1:0]    ref_sync, prb_sync;
  logic          ref_prev, prb_prev;
  logic [LW-1:0] gap_cnt;
  logic [SW-1:0] settle_cnt;
  logic          seq_q, en_q;

  wire ref_rise = ref_sync[1] & ~ref_prev;
  wire prb_rise = prb_sync[1] & ~prb_prev;
  wire lost     = (gap_cnt == LW'(LOSS_CYCLES));
  wire ready    = (settle_cnt == SW'(SETTLE_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sync <= '0;
      prb_sync <= '0;
      ref_prev <= 1'b0;
      prb_prev <= 1'b0;
    end else begin
      ref_sync <= {ref_sync[0], ref_half_i};
      prb_sync <= {prb_sync[0], probe_half_i};
      ref_prev <= ref_sync[1];
      prb_prev <= prb_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_cnt <= LW'(LOSS_CYCLES);
    else if (ref_rise) gap_cnt <= '0;
    else if (!lost) gap_cnt <= gap_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_cnt <= '0;
    else if (lost) settle_cnt <= '0;
    else if (!ready) settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (prb_rise) seq_q <= ref_sync[1];
      if (lost) en_q <= 1'b0;
      else if (prb_rise) en_q <= ready;
    end
  end

  assign drive_straight_o = en_q & seq_q;
  assign drive_swapped_o  = en_q & ~seq_q;

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_straight_o && drive_swapped_o));

  assert_loss_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !(drive_straight_o || drive_swapped_o));

  assert_settled_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_straight_o || drive_swapped_o) |-> $past(ready));

  assert_edge_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drive_straight_o) || $rose(drive_swapped_o)) |-> $past(prb_rise));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> !(drive_straight_o || drive_swapped_o));
endmodule

// File: tb/sim_phase_order_interlock.sv
module sim_phase_order_interlock;
  localparam int SETTLE = 400;
  localparam int LOSS   = 90;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0;
  logic prb_i = 1'b0;
  logic straight, swapped;
  int checks = 0;
  int errors = 0;
  int both_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phase_order_interlock #(.SETTLE_CYCLES(SETTLE), .LOSS_CYCLES(LOSS)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_half_i(ref_i), .probe_half_i(prb_i),
    .drive_straight_o(straight), .drive_swapped_o(swapped));

  always @(negedge clk) if (rst_n && straight && swapped) both_seen++;

  function automatic logic [1:0] expect_pair(bit enabled, bit in_order);
    return enabled ? (in_order ? 2'b10 : 2'b01) : 2'b00;
  endfunction

  function automatic int lag_of(int p, bit in_order);
    return in_order ? p / 3 : (2 * p) / 3;
  endfunction

  task automatic check(string tag, logic [1:0] exp);
    checks++;
    if ({straight, swapped} !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, {straight, swapped}, exp);
    end
  endtask

  task automatic drive(int n, int p, int off, bit ref_on, bit prb_on);
    for (int t = 0; t < n * p; t++) begin
      @(negedge clk);
      ref_i = ref_on && ((t % p) < p / 2);
      prb_i = prb_on && (((t + p - off) % p) < p / 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 2'b00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", 2'b00);

    drive(4, 60, 20, 1, 1);
    check("R4 before settle", 2'b00);
    drive(8, 60, 20, 1, 1);
    check("R2 straight order", expect_pair(1, 1));

    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      ref_i = (t % 60) < 30;
      prb_i = ((t + 60 - 40) % 60) < 30;
      if (t == 41) check("R8 holds until probe edge", 2'b10);
    end
    drive(1, 60, 40, 1, 1);
    check("R8 rewire takes effect", 2'b01);
    check("R3 swapped order", expect_pair(1, 0));

    drive(2, 60, 40, 0, 0);
    check("R6 both inputs gone", 2'b00);
    drive(5, 60, 40, 1, 1);
    check("R7 restart delay", 2'b00);
    drive(6, 60, 40, 1, 1);
    check("R3 after restart", expect_pair(1, 0));

    for (int k = 0; k < 5; k++) begin
      drive(3, 60, 20, 1, 1);
      drive(2, 60, 20, 0, 1);
    end
    check("R7 chatter keeps off", 2'b00);

    void'($urandom(1234));
    for (int it = 0; it < 10; it++) begin
      int p = 40 + int'($urandom % 21);
      bit ord = $urandom % 2;
      int off = lag_of(p, ord);
      drive(3, p, off, 0, 1);
      check("R6 reference lost", 2'b00);
      drive(3, p, off, 1, 1);
      check("R7 random restart", 2'b00);
      drive(12, p, off, 1, 1);
      check(ord ? "R2 random order" : "R3 random order", expect_pair(1, ord));
    end

    checks++;
    if (both_seen != 0) begin
      errors++;
      $display("FAIL R5 both-high cycles actual=%0d expected=0", both_seen);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule